// File: doc/BRIEF.md
# Trio symbol decoder

This block takes the sampled result of three differential comparators on a three-wire trio. The comparators look at the A-B, B-C and C-A differences, and the block gets one sample per unit interval, marked by a valid strobe. It turns each sample into one of six legal wire states. Each state is a position on a hexagon, and opposite corners of the hexagon are polarity inversions of each other. The step from the previous state to the current one gives a transition symbol with a value from 0 to 4.

Seven such symbols form a base-5 number, with the first symbol as the most significant digit. The block converts this number into a 16-bit word. It flags three kinds of fault in sticky error bits: a comparator pattern that no legal state can produce, a wire state that does not change between two samples, and a group whose value does not fit in 16 bits.

A sync input puts the decoder back at a group boundary and drops its reference state. It is used when a burst starts or after the link has lost alignment. An optional input register stage can be chosen by a parameter. It adds one cycle of latency to every output.

Top module: `trio_symbol_decoder`

## Requirements
- R1: `cmp_i` bit 2 is the sign of A-B, bit 1 the sign of B-C and bit 0 the sign of C-A, where 1 means positive. A valid sample with pattern 000 or 111 sets `err_state_o` on the next edge, produces no symbol, drops the partial group and clears the reference state.
- R2: The legal patterns map to hexagon positions 0 to 5 in this order: 001, 011, 010, 110, 100, 101. Positions three apart are inversions of each other.
- R3: A legal valid sample with a reference state present produces `sym_o` = ((cur - prev) mod 6) - 1, a value from 0 to 4. `sym_vld_o` is high for exactly the cycle after that sample's edge.
- R4: A legal sample equal to the reference state sets `err_seq_o`, produces no symbol and drops the partial group. The reference state is kept.
- R5: On the seventh symbol of a group, `word_o` takes the base-5 value of the group, first symbol most significant. `word_vld_o` is high for the single following cycle.
- R6: A completed group whose value exceeds 65535 gives no `word_vld_o` and sets `err_range_o` instead.
- R7: The first legal sample after reset, after sync or after an invalid pattern only loads the reference state and produces no symbol.
- R8: `sync_i` clears the group counter and the reference state. A sample presented in the same cycle as sync is ignored.
- R9: Each error flag stays set until `err_clr_i` is high. When a new error and a clear arrive in the same cycle, the flag stays set.
- R10: After reset all outputs are zero.
- R11: A cycle with `smp_valid_i` low changes neither the reference state nor the group, whatever `cmp_i` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Drop the group and the reference state |
| smp_valid_i | input | 1 | `cmp_i` holds a unit-interval sample |
| cmp_i | input | 3 | Comparator signs {A-B, B-C, C-A} |
| err_clr_i | input | 1 | Clear the sticky error flags |
| sym_o | output | 3 | Last transition symbol, 0 to 4 |
| sym_vld_o | output | 1 | `sym_o` holds a new symbol |
| word_o | output | 16 | Last decoded data word |
| word_vld_o | output | 1 | One-cycle pulse for a new word |
| err_state_o | output | 1 | Sticky: illegal comparator pattern seen |
| err_seq_o | output | 1 | Sticky: wire state did not change |
| err_range_o | output | 1 | Sticky: group value above 16 bits |

## Verification
A corrupted reference state shows up on the very next legal sample: `sym_o` carries the wrong value, or a symbol appears or goes missing, one cycle after the sample. A group counter that is off by one moves or removes the `word_vld_o` pulse in the same group. A wrong digit weight changes `word_o` when the group completes, at most seven samples later. The error flags are observed directly, so losing a flag or not holding it shows up on the first idle cycle after the error or after the clear.

// File: rtl/trio_pkg.sv
package trio_pkg;

   typedef logic [2:0] cmp_t;   // {sign A-B, sign B-C, sign C-A}
   typedef logic [2:0] hex_t;   // hexagon position 0..5

   localparam int unsigned HEX_N   = 6;
   localparam int unsigned RADIX   = 5;

   function automatic longint unsigned pow5(input int unsigned n);
      longint unsigned r;
      r = 1;
      for (int unsigned i = 0; i < n; i++) r = r * RADIX;
      return r;
   endfunction

endpackage

// File: rtl/trio_classify.sv
module trio_classify
   import trio_pkg::*;
(
   input  cmp_t cmp_i,
   output logic legal_o,
   output hex_t pos_o
);

   // Hexagon walk: adjacent steps rotate the wire levels or flip polarity,
   // positions three apart are exact complements of each other.
   always_comb begin
      legal_o = 1'b1;
      pos_o   = 3'd0;
      case (cmp_i)
         3'b001:  pos_o = 3'd0;
         3'b011:  pos_o = 3'd1;
         3'b010:  pos_o = 3'd2;
         3'b110:  pos_o = 3'd3;
         3'b100:  pos_o = 3'd4;
         3'b101:  pos_o = 3'd5;
         default: legal_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/trio_transition.sv
module trio_transition
   import trio_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic sync_i,
   input  logic valid_i,
   input  logic legal_i,
   input  hex_t pos_i,
   output logic fire_o,
   output logic [2:0] sym_o,
   output logic bad_o,
   output logic rep_o
);

   logic       ref_ok_q;
   hex_t       ref_pos_q;
   logic       take;
   logic [3:0] step;

   assign take = valid_i && !sync_i;

   always_comb begin
      if (pos_i >= ref_pos_q)
         step = {1'b0, pos_i} - {1'b0, ref_pos_q};
      else
         step = {1'b0, pos_i} + 4'(HEX_N) - {1'b0, ref_pos_q};
   end

   assign bad_o  = take && !legal_i;
   assign rep_o  = take && legal_i && ref_ok_q && (step == 4'd0);
   assign fire_o = take && legal_i && ref_ok_q && (step != 4'd0);
   assign sym_o  = step[2:0] - 3'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ref_ok_q  <= 1'b0;
         ref_pos_q <= 3'd0;
      end else if (sync_i) begin
         ref_ok_q  <= 1'b0;
      end else if (take) begin
         if (!legal_i) begin
            ref_ok_q  <= 1'b0;
         end else begin
            ref_ok_q  <= 1'b1;
            ref_pos_q <= pos_i;
         end
      end
   end

endmodule

// File: rtl/trio_word_packer.sv
module trio_word_packer #(
   parameter int unsigned SYMS   = 7,
   parameter int unsigned WORD_W = 16,
   parameter int unsigned ACC_W  = 17,
   parameter int unsigned CNT_W  = 3
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              abort_i,
   input  logic              fire_i,
   input  logic [2:0]        sym_i,
   output logic [WORD_W-1:0] word_o,
   output logic              word_vld_o,
   output logic              ovf_o
);

   logic [CNT_W-1:0] cnt_q;
   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_nx;
   logic             last;
   logic             too_big;

   // acc * 5 + digit, built from a shift and two adds
   assign acc_nx  = (acc_q << 2) + acc_q + ACC_W'(sym_i);
   assign last    = (cnt_q == CNT_W'(SYMS - 1));
   assign too_big = |acc_nx[ACC_W-1:WORD_W];
   assign ovf_o   = fire_i && !abort_i && last && too_big;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         acc_q      <= '0;
         word_o     <= '0;
         word_vld_o <= 1'b0;
      end else begin
         word_vld_o <= 1'b0;
         if (abort_i) begin
            cnt_q <= '0;
            acc_q <= '0;
         end else if (fire_i) begin
            if (last) begin
               cnt_q <= '0;
               acc_q <= '0;
               if (!too_big) begin
                  word_o     <= acc_nx[WORD_W-1:0];
                  word_vld_o <= 1'b1;
               end
            end else begin
               cnt_q <= cnt_q + 1'b1;
               acc_q <= acc_nx;
            end
         end
      end
   end

endmodule

// File: rtl/trio_symbol_decoder.sv
module trio_symbol_decoder #(
   parameter int unsigned SYMS_PER_WORD = 7,
   parameter int unsigned WORD_W        = 16,
   parameter bit          IN_STAGE      = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sync_i,
   input  logic              smp_valid_i,
   input  logic [2:0]        cmp_i,
   input  logic              err_clr_i,
   output logic [2:0]        sym_o,
   output logic              sym_vld_o,
   output logic [WORD_W-1:0] word_o,
   output logic              word_vld_o,
   output logic              err_state_o,
   output logic              err_seq_o,
   output logic              err_range_o
);
   import trio_pkg::*;

   localparam int unsigned ACC_W = $clog2(pow5(SYMS_PER_WORD));
   localparam int unsigned CNT_W = $clog2(SYMS_PER_WORD);

   if (SYMS_PER_WORD < 2) begin : g_bad_syms
      $error("SYMS_PER_WORD must be at least 2");
   end
   if (ACC_W <= WORD_W) begin : g_bad_width
      $error("group value range must exceed WORD_W bits");
   end

   logic  s_sync, s_vld, s_clr;
   cmp_t  s_cmp;

   if (IN_STAGE) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            s_sync <= 1'b0;
            s_vld  <= 1'b0;
            s_clr  <= 1'b0;
            s_cmp  <= '0;
         end else begin
            s_sync <= sync_i;
            s_vld  <= smp_valid_i;
            s_clr  <= err_clr_i;
            s_cmp  <= cmp_i;
         end
      end
   end else begin : g_pass
      assign s_sync = sync_i;
      assign s_vld  = smp_valid_i;
      assign s_clr  = err_clr_i;
      assign s_cmp  = cmp_i;
   end

   logic       legal, fire, bad, rep, ovf;
   hex_t       pos;
   logic [2:0] sym;

   trio_classify i_classify (
      .cmp_i   (s_cmp),
      .legal_o (legal),
      .pos_o   (pos)
   );

   trio_transition i_transition (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_i  (s_sync),
      .valid_i (s_vld),
      .legal_i (legal),
      .pos_i   (pos),
      .fire_o  (fire),
      .sym_o   (sym),
      .bad_o   (bad),
      .rep_o   (rep)
   );

   trio_word_packer #(
      .SYMS   (SYMS_PER_WORD),
      .WORD_W (WORD_W),
      .ACC_W  (ACC_W),
      .CNT_W  (CNT_W)
   ) i_packer (
      .clk        (clk),
      .rst_n      (rst_n),
      .abort_i    (s_sync | bad | rep),
      .fire_i     (fire),
      .sym_i      (sym),
      .word_o     (word_o),
      .word_vld_o (word_vld_o),
      .ovf_o      (ovf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sym_o       <= '0;
         sym_vld_o   <= 1'b0;
         err_state_o <= 1'b0;
         err_seq_o   <= 1'b0;
         err_range_o <= 1'b0;
      end else begin
         sym_vld_o <= fire;
         if (fire) sym_o <= sym;

         if (bad)        err_state_o <= 1'b1;
         else if (s_clr) err_state_o <= 1'b0;

         if (rep)        err_seq_o <= 1'b1;
         else if (s_clr) err_seq_o <= 1'b0;

         if (ovf)        err_range_o <= 1'b1;
         else if (s_clr) err_range_o <= 1'b0;
      end
   end

endmodule

// File: rtl/trio_symbol_decoder_chk.sv
module trio_symbol_decoder_chk #(
   parameter bit IN_STAGE = 1'b0
)(
   input logic       clk,
   input logic       rst_n,
   input logic       sync_i,
   input logic       smp_valid_i,
   input logic [2:0] cmp_i,
   input logic       err_clr_i,
   input logic [2:0] sym_o,
   input logic       sym_vld_o,
   input logic       word_vld_o,
   input logic       err_state_o,
   input logic       err_seq_o,
   input logic       err_range_o
);

   p_sym_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sym_vld_o |-> (sym_o <= 3'd4));

   p_word_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      word_vld_o |=> !word_vld_o);

   if (!IN_STAGE) begin : g_direct
      p_bad_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
         (smp_valid_i && !sync_i && (cmp_i == 3'b000 || cmp_i == 3'b111))
         |=> (err_state_o && !sym_vld_o));

      p_ref_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
         sync_i |-> ##2 !sym_vld_o);

      p_sync_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
         sync_i |=> (!sym_vld_o && !word_vld_o));

      p_state_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (err_state_o && !err_clr_i) |=> err_state_o);

      p_seq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (err_seq_o && !err_clr_i) |=> err_seq_o);

      p_range_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (err_range_o && !err_clr_i) |=> err_range_o);

      p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
         (err_clr_i && !smp_valid_i && !sync_i)
         |=> (!err_state_o && !err_seq_o && !err_range_o));
   end

endmodule

bind trio_symbol_decoder trio_symbol_decoder_chk #(.IN_STAGE(IN_STAGE)) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .sync_i      (sync_i),
   .smp_valid_i (smp_valid_i),
   .cmp_i       (cmp_i),
   .err_clr_i   (err_clr_i),
   .sym_o       (sym_o),
   .sym_vld_o   (sym_vld_o),
   .word_vld_o  (word_vld_o),
   .err_state_o (err_state_o),
   .err_seq_o   (err_seq_o),
   .err_range_o (err_range_o)
);

// File: tb/test_trio_symbol_decoder.sv
`timescale 1ns/1ps
module test_trio_symbol_decoder;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        sync_i, smp_valid_i, err_clr_i;
   logic [2:0]  cmp_i;
   logic [2:0]  sym_o;
   logic        sym_vld_o;
   logic [15:0] word_o;
   logic        word_vld_o;
   logic        err_state_o, err_seq_o, err_range_o;

   always #2.5 clk = ~clk;

   trio_symbol_decoder i_trio_symbol_decoder (
      .clk(clk), .rst_n(rst_n), .sync_i(sync_i), .smp_valid_i(smp_valid_i),
      .cmp_i(cmp_i), .err_clr_i(err_clr_i), .sym_o(sym_o), .sym_vld_o(sym_vld_o),
      .word_o(word_o), .word_vld_o(word_vld_o), .err_state_o(err_state_o),
      .err_seq_o(err_seq_o), .err_range_o(err_range_o)
   );

   int n_cmp = 0;
   int n_bad = 0;
   bit finished = 1'b0;
   int cur_h;

   // Group digits (first most significant) and whether the value overflows 16 bits
   localparam int NV = 6;
   localparam int VSYM [NV][7] = '{
      '{0,0,0,0,0,0,0},
      '{4,0,4,4,1,2,0},
      '{4,0,4,4,1,2,1},
      '{1,2,3,4,0,1,2},
      '{3,2,1,0,4,3,2},
      '{4,4,4,4,4,4,4}
   };
   localparam bit VOVF [NV] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

   // R2 hexagon order
   function automatic logic [2:0] pat(input int h);
      case (h)
         0: return 3'b001;
         1: return 3'b011;
         2: return 3'b010;
         3: return 3'b110;
         4: return 3'b100;
         default: return 3'b101;
      endcase
   endfunction

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // drive at a falling edge, return at the next falling edge with inputs idle
   task automatic apply(input bit v, input logic [2:0] c, input bit s, input bit clr);
      smp_valid_i = v; cmp_i = c; sync_i = s; err_clr_i = clr;
      @(negedge clk);
      smp_valid_i = 1'b0; sync_i = 1'b0; err_clr_i = 1'b0;
   endtask

   task automatic run_digits(input int dg[7], input bit ovf, input string req);
      longint w = 0;
      for (int k = 0; k < 7; k++) begin
         w = w * 5 + dg[k];
         cur_h = (cur_h + dg[k] + 1) % 6;
         apply(1'b1, pat(cur_h), 1'b0, 1'b0);
         chk("R3", "sym_vld", sym_vld_o, 1);
         chk("R3", "sym", sym_o, dg[k]);
         if (k < 6) chk("R5", "word_vld early", word_vld_o, 0);
      end
      if (ovf) begin
         chk("R6", "word_vld on overflow", word_vld_o, 0);
         chk("R6", "err_range", err_range_o, 1);
      end else begin
         chk(req, "word_vld", word_vld_o, 1);
         chk(req, "word", word_o, w);
         chk("R6", "err_range quiet", err_range_o, 0);
      end
      apply(1'b0, 3'b000, 1'b0, 1'b0);
      chk("R5", "word_vld one cycle", word_vld_o, 0);
   endtask

   initial begin
      int dg[7];
      rst_n = 1'b0; sync_i = 1'b0; smp_valid_i = 1'b0; err_clr_i = 1'b0; cmp_i = 3'b000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R10 reset state
      chk("R10", "outputs after reset",
          {sym_o, sym_vld_o, word_o, word_vld_o, err_state_o, err_seq_o, err_range_o}, 0);

      // vector table
      for (int vi = 0; vi < NV; vi++) begin
         apply(1'b0, 3'b000, 1'b1, 1'b1);
         cur_h = vi % 6;
         apply(1'b1, pat(cur_h), 1'b0, 1'b0);
         chk("R7", "no symbol on reference sample", sym_vld_o, 0);
         for (int k = 0; k < 7; k++) dg[k] = VSYM[vi][k];
         run_digits(dg, VOVF[vi], "R5");
      end

      // R2: inversion is three positions away; adjacent step is one
      apply(1'b0, 3'b000, 1'b1, 1'b1);
      apply(1'b1, 3'b001, 1'b0, 1'b0);
      apply(1'b1, 3'b110, 1'b0, 1'b0);
      chk("R2", "inversion symbol", sym_o, 2);
      apply(1'b1, 3'b100, 1'b0, 1'b0);
      chk("R2", "adjacent symbol", sym_o, 0);
      // R11: idle cycle with a different pattern leaves group and reference untouched
      apply(1'b0, 3'b011, 1'b0, 1'b0);
      chk("R11", "no symbol while idle", sym_vld_o, 0);
      cur_h = 4;
      begin
         int tail[5] = '{1, 2, 3, 4, 0};
         for (int k = 0; k < 5; k++) begin
            cur_h = (cur_h + tail[k] + 1) % 6;
            apply(1'b1, pat(cur_h), 1'b0, 1'b0);
            chk("R11", "sym after idle", sym_o, tail[k]);
         end
         chk("R11", "word_vld", word_vld_o, 1);
         chk("R11", "word", word_o, 32220);
      end

      // R1: illegal patterns
      apply(1'b0, 3'b000, 1'b1, 1'b1);
      apply(1'b1, pat(0), 1'b0, 1'b0);
      apply(1'b1, 3'b000, 1'b0, 1'b0);
      chk("R1", "err_state on 000", err_state_o, 1);
      chk("R1", "no symbol on 000", sym_vld_o, 0);
      apply(1'b1, pat(2), 1'b0, 1'b0);
      chk("R7", "reference reloaded after illegal", sym_vld_o, 0);
      apply(1'b1, pat(3), 1'b0, 1'b0);
      chk("R1", "symbol resumes", {sym_vld_o, sym_o}, {1'b1, 3'd0});
      apply(1'b1, 3'b111, 1'b1 ^ 1'b1, 1'b1);
      chk("R9", "set wins over clear (111)", err_state_o, 1);
      apply(1'b0, 3'b000, 1'b0, 1'b0);
      apply(1'b0, 3'b000, 1'b0, 1'b0);
      chk("R9", "err_state held", err_state_o, 1);
      apply(1'b0, 3'b000, 1'b0, 1'b1);
      chk("R9", "err_state cleared", err_state_o, 0);

      // R4: repeated state drops the partial group
      apply(1'b0, 3'b000, 1'b1, 1'b1);
      cur_h = 0;
      apply(1'b1, pat(0), 1'b0, 1'b0);
      for (int k = 1; k <= 3; k++) apply(1'b1, pat(k), 1'b0, 1'b0);
      apply(1'b1, pat(3), 1'b0, 1'b0);
      chk("R4", "err_seq", err_seq_o, 1);
      chk("R4", "no symbol on repeat", sym_vld_o, 0);
      cur_h = 3;
      for (int k = 0; k < 7; k++) dg[k] = 1;
      run_digits(dg, 1'b0, "R4");
      chk("R9", "err_seq held", err_seq_o, 1);

      // R8: sync mid-group with a sample in the same cycle
      apply(1'b0, 3'b000, 1'b1, 1'b1);
      apply(1'b1, pat(0), 1'b0, 1'b0);
      for (int k = 1; k <= 3; k++) apply(1'b1, pat(k), 1'b0, 1'b0);
      apply(1'b1, pat(5), 1'b1, 1'b0);
      chk("R8", "no symbol with sync", {sym_vld_o, word_vld_o}, 0);
      apply(1'b1, pat(5), 1'b0, 1'b0);
      chk("R8", "first sample after sync", sym_vld_o, 0);
      cur_h = 5;
      dg = '{4, 0, 0, 0, 0, 0, 0};
      run_digits(dg, 1'b0, "R8");

      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule